// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block holds fifteen outgoing CAN messages, one per mailbox, and feeds them to a bit-level CAN engine one at a time. Software loads a whole mailbox (identifier, frame format, remote-request flag, length code, eight data bytes) through a load port. It then pulses that mailbox's pending bit. The scheduler picks the pending mailbox whose frame would win bus arbitration. It presents a shaped frame descriptor to the engine over a valid/ready request, and waits for the engine's one-cycle completion report.

A successful report retires the mailbox: its pending bit drops and its sent flag rises in the same clock edge. A lost arbitration or any transmit error leaves the mailbox pending, so it competes again at the next selection with no software action. Sent flags are cleared by writing ones. A level interrupt stays asserted while any sent flag is set whose own enable and the global enable are both on.

Top module: `can_txmb_ctrl`

## Requirements
- R1: A load with `ld_en` high stores all mailbox fields into mailbox `ld_idx` (1..15). When that mailbox is sent, its identifier, `req_ide`, `req_rtr`, length and data appear on the request port.
- R2: With `req_ide` = 0 (standard format) only identifier bits 28:18 are carried, and `req_id[17:0]` reads 0. With `req_ide` = 1 (extended format) all 29 bits are carried.
- R3: `req_dlc` equals the stored length code clamped to 8. Codes 9..15 go out as 8.
- R4: Data byte k (k = 0..7) sits at `req_data[8k+7:8k]`. Every byte with k >= `req_dlc` is presented as 0, whatever the mailbox holds.
- R5: A one-cycle pulse on bit m of `wait_set` sets `tx_wait[m]`. The mailbox is then offered with `req_valid` high.
- R6: A done report with `tx_stat` = 2'b01 (success) clears `tx_wait` and sets `tx_ack` of the mailbox in flight, both at the same clock edge.
- R7: A done report with `tx_stat` = 2'b10 (lost arbitration) or 2'b11 (error) leaves `tx_wait` set and `tx_ack` unchanged. The mailbox is offered again without software action.
- R8: Among pending mailboxes the one with the lowest arbitration key wins. The key is the 32-bit value {ID[28:18], X, IDE, Y, Z}. For standard frames X = RTR and Y, Z = 0. For extended frames X = 1, Y = ID[17:0] and Z = RTR. Equal keys go to the lowest mailbox number.
- R9: Selection is made anew before every attempt. A mailbox made pending while another is in flight wins the next attempt if its key is lower.
- R10: Writing 1 to bit m of `ack_clr` clears `tx_ack[m]`. A success for mailbox m at the same edge leaves `tx_ack[m]` set.
- R11: `irq` is high exactly while some `tx_ack[m]` with `mbx_ie[m]` = 1 is set and `empty_ie` = 1.
- R12: While `req_valid` is high and `req_ready` is low, `req_valid` and all descriptor fields hold steady.
- R13: After reset, `tx_wait`, `tx_ack`, `irq` and `req_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load strobe for one mailbox |
| ld_idx | input | 4 | Mailbox number to load, 1..15 |
| ld_id | input | 29 | Identifier, bits 28:0 |
| ld_ide | input | 1 | 1 = extended format |
| ld_rtr | input | 1 | Remote request flag |
| ld_dlc | input | 4 | Length code |
| ld_data | input | 64 | Data bytes, byte k at bits 8k+7:8k |
| wait_set | input | 15 | Pulse per mailbox to make it pending |
| ack_clr | input | 15 | Write-one-to-clear of sent flags |
| mbx_ie | input | 15 | Per-mailbox interrupt enable |
| empty_ie | input | 1 | Global mailbox-empty interrupt enable |
| tx_wait | output | 15 | Pending bits |
| tx_ack | output | 15 | Sent flags |
| irq | output | 1 | Level interrupt |
| req_valid | output | 1 | Frame offered to the engine |
| req_ready | input | 1 | Engine takes the frame |
| req_id | output | 29 | Shaped identifier |
| req_ide | output | 1 | Frame format |
| req_rtr | output | 1 | Remote request flag |
| req_dlc | output | 4 | Clamped length |
| req_data | output | 64 | Masked data |
| tx_done | input | 1 | One-cycle completion pulse |
| tx_stat | input | 2 | 01 success, 10 lost arbitration, 11 error |

## Verification
A wrong in-flight mailbox index shows at the next completion edge. The wrong bit of `tx_ack` rises and the wrong bit of `tx_wait` drops, visible one cycle after the done pulse. A faulty selection shows up two cycles after the engine goes idle, as a descriptor whose identifier is not the lowest pending key. Errors in the shaping path corrupt `req_id`, `req_dlc` or `req_data` the moment `req_valid` rises. A retry that wrongly retires the mailbox leaves `tx_wait` low one cycle after a failed report.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;

   localparam int CAN_ID_W    = 29;
   localparam int BASE_ID_W   = 11;
   localparam int MAX_BYTES   = 8;
   localparam int DATA_W      = 8 * MAX_BYTES;
   localparam int DLC_W       = 4;
   localparam int KEY_W       = BASE_ID_W + 3 + (CAN_ID_W - BASE_ID_W);

   typedef enum logic [1:0] {
      TXS_NONE = 2'b00,
      TXS_OK   = 2'b01,
      TXS_LOST = 2'b10,
      TXS_ERR  = 2'b11
   } tx_stat_e;

   typedef struct packed {
      logic [CAN_ID_W-1:0] id;
      logic                ide;
      logic                rtr;
      logic [DLC_W-1:0]    dlc;
      logic [DATA_W-1:0]   data;
   } mbx_t;

   // Bus-order arbitration key: lower value wins on the wire.
   function automatic logic [KEY_W-1:0] arb_key(input mbx_t m);
      logic [KEY_W-1:0] k;
      if (m.ide)
         k = {m.id[CAN_ID_W-1 -: BASE_ID_W], 1'b1, 1'b1,
              m.id[CAN_ID_W-BASE_ID_W-1:0], m.rtr};
      else
         k = {m.id[CAN_ID_W-1 -: BASE_ID_W], m.rtr, 1'b0,
              {(CAN_ID_W-BASE_ID_W){1'b0}}, 1'b0};
      return k;
   endfunction

   // Frame as the engine must see it: format-trimmed ID, clamped length, masked bytes.
   function automatic mbx_t shape(input mbx_t m);
      mbx_t s;
      s = m;
      if (!m.ide)
         s.id[CAN_ID_W-BASE_ID_W-1:0] = '0;
      s.dlc = (m.dlc > DLC_W'(MAX_BYTES)) ? DLC_W'(MAX_BYTES) : m.dlc;
      for (int b = 0; b < MAX_BYTES; b++)
         if (DLC_W'(b) >= s.dlc)
            s.data[8*b +: 8] = 8'h00;
      return s;
   endfunction

endpackage

// File: rtl/can_txmb_store.sv
module can_txmb_store
   import can_txmb_pkg::*;
#(
   parameter int NMBX  = 15,
   parameter int IDX_W = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [IDX_W-1:0]  ld_idx,
   input  mbx_t              ld_word,
   output mbx_t [NMBX:1]     mbx_q
);

   for (genvar g = 1; g <= NMBX; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mbx_q[g] <= '0;
         else if (ld_en && ld_idx == IDX_W'(g))
            mbx_q[g] <= ld_word;
      end
   end

endmodule

// File: rtl/can_txmb_arb.sv
module can_txmb_arb
   import can_txmb_pkg::*;
#(
   parameter int NMBX  = 15,
   parameter int IDX_W = 4
)(
   input  mbx_t [NMBX:1]     mbx,
   input  logic [NMBX:1]     pend,
   output logic              found,
   output logic [IDX_W-1:0]  win_idx
);

   logic [KEY_W-1:0] best;
   logic [KEY_W-1:0] key;

   // Ascending scan with strict compare: equal keys keep the lower mailbox.
   always_comb begin
      found   = 1'b0;
      win_idx = '0;
      best    = '1;
      key     = '0;
      for (int i = 1; i <= NMBX; i++) begin
         key = arb_key(mbx[i]);
         if (pend[i] && (!found || key < best)) begin
            found   = 1'b1;
            best    = key;
            win_idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/can_txmb_flags.sv
module can_txmb_flags #(
   parameter int NMBX    = 15,
   parameter int IDX_W   = 4,
   parameter bit REG_IRQ = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NMBX:1]     sw_set,
   input  logic [NMBX:1]     sw_clr,
   input  logic              hw_ok,
   input  logic [IDX_W-1:0]  hw_idx,
   input  logic [NMBX:1]     mbx_ie,
   input  logic              empty_ie,
   output logic [NMBX:1]     wait_q,
   output logic [NMBX:1]     ack_q,
   output logic              irq
);

   logic [NMBX:1] hw_hit;
   logic          irq_d;

   for (genvar g = 1; g <= NMBX; g++) begin : g_dec
      assign hw_hit[g] = hw_ok && (hw_idx == IDX_W'(g));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_q <= '0;
         ack_q  <= '0;
      end else begin
         wait_q <= (wait_q & ~hw_hit) | sw_set;
         ack_q  <= (ack_q & ~sw_clr) | hw_hit;
      end
   end

   assign irq_d = empty_ie && |(ack_q & mbx_ie);

   if (REG_IRQ) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= irq_d;
      end
   end else begin : g_irq_comb
      assign irq = irq_d;
   end

endmodule

// File: rtl/can_txmb_ctrl.sv
module can_txmb_ctrl
   import can_txmb_pkg::*;
#(
   parameter int NMBX    = 15,
   parameter bit REG_IRQ = 1'b0,
   localparam int IDX_W  = $clog2(NMBX + 1)
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ld_en,
   input  logic [IDX_W-1:0]     ld_idx,
   input  logic [CAN_ID_W-1:0]  ld_id,
   input  logic                 ld_ide,
   input  logic                 ld_rtr,
   input  logic [DLC_W-1:0]     ld_dlc,
   input  logic [DATA_W-1:0]    ld_data,
   input  logic [NMBX:1]        wait_set,
   input  logic [NMBX:1]        ack_clr,
   input  logic [NMBX:1]        mbx_ie,
   input  logic                 empty_ie,
   output logic [NMBX:1]        tx_wait,
   output logic [NMBX:1]        tx_ack,
   output logic                 irq,
   output logic                 req_valid,
   input  logic                 req_ready,
   output logic [CAN_ID_W-1:0]  req_id,
   output logic                 req_ide,
   output logic                 req_rtr,
   output logic [DLC_W-1:0]     req_dlc,
   output logic [DATA_W-1:0]    req_data,
   input  logic                 tx_done,
   input  logic [1:0]           tx_stat
);

   if (NMBX < 1 || NMBX > 15) begin : g_bad_nmbx
      $error("can_txmb_ctrl: NMBX must lie in 1..15");
   end

   typedef enum logic [1:0] {SEL = 2'd0, OFFER = 2'd1, BUSY = 2'd2} fsm_e;

   fsm_e             state;
   logic [IDX_W-1:0] cur_idx;
   mbx_t             desc_q;
   mbx_t             ld_word;
   mbx_t [NMBX:1]    mbx_q;
   logic             found;
   logic [IDX_W-1:0] win_idx;
   logic             hw_ok;

   assign ld_word = '{id: ld_id, ide: ld_ide, rtr: ld_rtr, dlc: ld_dlc, data: ld_data};

   can_txmb_store #(.NMBX(NMBX), .IDX_W(IDX_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (ld_en),
      .ld_idx  (ld_idx),
      .ld_word (ld_word),
      .mbx_q   (mbx_q)
   );

   can_txmb_arb #(.NMBX(NMBX), .IDX_W(IDX_W)) u_arb (
      .mbx     (mbx_q),
      .pend    (tx_wait),
      .found   (found),
      .win_idx (win_idx)
   );

   assign hw_ok = (state == BUSY) && tx_done && (tx_stat == TXS_OK);

   can_txmb_flags #(.NMBX(NMBX), .IDX_W(IDX_W), .REG_IRQ(REG_IRQ)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_set   (wait_set),
      .sw_clr   (ack_clr),
      .hw_ok    (hw_ok),
      .hw_idx   (cur_idx),
      .mbx_ie   (mbx_ie),
      .empty_ie (empty_ie),
      .wait_q   (tx_wait),
      .ack_q    (tx_ack),
      .irq      (irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SEL;
         cur_idx <= '0;
         desc_q  <= '0;
      end else begin
         unique case (state)
            SEL: if (found) begin
               state   <= OFFER;
               cur_idx <= win_idx;
               desc_q  <= shape(mbx_q[win_idx]);
            end
            OFFER: if (req_ready) state <= BUSY;
            BUSY:  if (tx_done)   state <= SEL;
            default: state <= SEL;
         endcase
      end
   end

   assign req_valid = (state == OFFER);
   assign req_id    = desc_q.id;
   assign req_ide   = desc_q.ide;
   assign req_rtr   = desc_q.rtr;
   assign req_dlc   = desc_q.dlc;
   assign req_data  = desc_q.data;

endmodule

// File: rtl/can_txmb_chk.sv
module can_txmb_chk
   import can_txmb_pkg::*;
#(
   parameter int NMBX  = 15,
   parameter int IDX_W = 4
)(
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic                 req_ready,
   input logic [CAN_ID_W-1:0]  req_id,
   input logic                 req_ide,
   input logic [DLC_W-1:0]     req_dlc,
   input logic [DATA_W-1:0]    req_data,
   input logic                 tx_done,
   input logic [1:0]           tx_stat,
   input logic [IDX_W-1:0]     cur_idx,
   input logic [NMBX:1]        tx_wait,
   input logic [NMBX:1]        tx_ack,
   input logic [NMBX:1]        wait_set,
   input logic [NMBX:1]        mbx_ie,
   input logic                 empty_ie,
   input logic                 irq,
   input logic                 busy
);

   logic stray_byte;
   always_comb begin
      stray_byte = 1'b0;
      for (int b = 0; b < MAX_BYTES; b++)
         if (DLC_W'(b) >= req_dlc && req_data[8*b +: 8] != 8'h00)
            stray_byte = 1'b1;
   end

   AST_STD_ID_TRIM: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ide |-> req_id[CAN_ID_W-BASE_ID_W-1:0] == '0);  // R2

   AST_DLC_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> req_dlc <= DLC_W'(MAX_BYTES));  // R3

   AST_DATA_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !stray_byte);  // R4

   AST_OK_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
      busy && tx_done && tx_stat == TXS_OK
      |=> tx_ack[$past(cur_idx)] && (!tx_wait[$past(cur_idx)] || $past(wait_set[cur_idx])));  // R6

   AST_FAIL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      busy && tx_done && (tx_stat == TXS_LOST || tx_stat == TXS_ERR)
      |=> tx_wait[$past(cur_idx)]);  // R7

   AST_ONE_ACK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tx_ack & ~$past(tx_ack)) <= 1);  // R6

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> empty_ie && |(tx_ack & mbx_ie));  // R11

   AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> req_valid && $stable(req_id) && $stable(req_dlc)
                                  && $stable(req_data));  // R12

endmodule

bind can_txmb_ctrl can_txmb_chk #(.NMBX(NMBX), .IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_id    (req_id),
   .req_ide   (req_ide),
   .req_dlc   (req_dlc),
   .req_data  (req_data),
   .tx_done   (tx_done),
   .tx_stat   (tx_stat),
   .cur_idx   (cur_idx),
   .tx_wait   (tx_wait),
   .tx_ack    (tx_ack),
   .wait_set  (wait_set),
   .mbx_ie    (mbx_ie),
   .empty_ie  (empty_ie),
   .irq       (irq),
   .busy      (state == 2'd2)
);

// File: tb/sim_can_txmb_ctrl.sv
`timescale 1ns/1ps
module sim_can_txmb_ctrl;

   localparam int NMBX = 15;
   localparam logic [63:0] PAT = 64'h8877_6655_4433_2211;

   typedef struct packed {
      logic [3:0]  mb;
      logic [28:0] id;
      logic        ide;
      logic        rtr;
      logic [3:0]  dlc;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{4'd1,  29'h00ABCDEF, 1'b0, 1'b0, 4'd8},
      '{4'd15, 29'h1FFFFFFF, 1'b1, 1'b1, 4'd0},
      '{4'd7,  29'h12345678, 1'b1, 1'b0, 4'd3},
      '{4'd9,  29'h1F000000, 1'b0, 1'b0, 4'd12},
      '{4'd3,  29'h00040001, 1'b0, 1'b1, 4'd15},
      '{4'd12, 29'h00000001, 1'b1, 1'b0, 4'd1}
   };

   logic        clk = 0;
   logic        rst_n = 0;
   logic        ld_en = 0;
   logic [3:0]  ld_idx = 0;
   logic [28:0] ld_id = 0;
   logic        ld_ide = 0, ld_rtr = 0;
   logic [3:0]  ld_dlc = 0;
   logic [63:0] ld_data = 0;
   logic [NMBX:1] wait_set = 0, ack_clr = 0, mbx_ie = 0;
   logic        empty_ie = 0;
   logic [NMBX:1] tx_wait, tx_ack;
   logic        irq, req_valid;
   logic        req_ready = 0;
   logic [28:0] req_id;
   logic        req_ide, req_rtr;
   logic [3:0]  req_dlc;
   logic [63:0] req_data;
   logic        tx_done = 0;
   logic [1:0]  tx_stat = 0;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   can_txmb_ctrl u0 (.*);

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic load(input logic [3:0] mb, input logic [28:0] id, input logic ide,
                       input logic rtr, input logic [3:0] dlc);
      @(negedge clk);
      ld_en = 1; ld_idx = mb; ld_id = id; ld_ide = ide; ld_rtr = rtr;
      ld_dlc = dlc; ld_data = PAT;
      @(negedge clk);
      ld_en = 0;
   endtask

   task automatic pend(input logic [NMBX:1] m);
      @(negedge clk); wait_set = m;
      @(negedge clk); wait_set = 0;
   endtask

   // Engine model: accept the offer, then report one outcome.
   task automatic serve(input logic [1:0] st, input logic [NMBX:1] clr,
                        input logic [NMBX:1] setm, output logic [28:0] id_o,
                        output logic ide_o, output logic rtr_o,
                        output logic [3:0] dlc_o, output logic [63:0] dat_o);
      int t;
      t = 0;
      while (!req_valid && t < 50) begin @(negedge clk); t++; end
      check("R5 offer seen", {63'd0, req_valid}, 64'd1);
      id_o = req_id; ide_o = req_ide; rtr_o = req_rtr; dlc_o = req_dlc; dat_o = req_data;
      req_ready = 1;
      @(negedge clk); req_ready = 0;
      @(negedge clk); tx_done = 1; tx_stat = st; ack_clr = clr; wait_set = setm;
      @(negedge clk); tx_done = 0; tx_stat = 0; ack_clr = 0; wait_set = 0;
   endtask

   function automatic logic [63:0] mask_exp(input logic [3:0] n);
      logic [63:0] r;
      r = PAT;
      for (int b = 0; b < 8; b++) if (b >= n) r[8*b +: 8] = 8'h00;
      return r;
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [28:0] id; logic ide, rtr; logic [3:0] dlc; logic [63:0] dat;
      logic [3:0] edlc;
      repeat (3) @(negedge clk);
      // R13 reset state
      check("R13 wait", 64'(tx_wait), 0);
      check("R13 ack", 64'(tx_ack), 0);
      check("R13 irq/valid", {62'd0, irq, req_valid}, 0);
      rst_n = 1;
      @(negedge clk);

      // Table walk: R1 R2 R3 R4 R5 R6
      for (int v = 0; v < 6; v++) begin
         load(VECS[v].mb, VECS[v].id, VECS[v].ide, VECS[v].rtr, VECS[v].dlc);
         pend(15'(1) << (VECS[v].mb - 1));
         serve(2'b01, 0, 0, id, ide, rtr, dlc, dat);
         edlc = (VECS[v].dlc > 8) ? 4'd8 : VECS[v].dlc;
         check("R2 id", 64'(id), VECS[v].ide ? 64'(VECS[v].id) : 64'({VECS[v].id[28:18], 18'd0}));
         check("R1 ide/rtr", {62'd0, ide, rtr}, {62'd0, VECS[v].ide, VECS[v].rtr});
         check("R3 dlc", 64'(dlc), 64'(edlc));
         check("R4 data", dat, mask_exp(edlc));
         check("R6 ack set", 64'(tx_ack[VECS[v].mb]), 1);
         check("R6 wait clear", 64'(tx_wait[VECS[v].mb]), 0);
      end

      // R11 interrupt gating; mailboxes 1,3,7,9,12,15 have ack set
      @(negedge clk);
      mbx_ie = 15'h7FFF; empty_ie = 0; #1;
      check("R11 global off", 64'(irq), 0);
      mbx_ie = 15'(1) << 1; empty_ie = 1; #1;  // mailbox 2, ack clear
      check("R11 mailbox off", 64'(irq), 0);
      mbx_ie = 15'(1) << 6; #1;                // mailbox 7
      check("R11 both on", 64'(irq), 1);
      @(negedge clk); ack_clr = 15'(1) << 6;
      @(negedge clk); ack_clr = 0;
      check("R10 w1c", 64'(tx_ack[7]), 0);
      check("R11 cleared", 64'(irq), 0);
      mbx_ie = 0; empty_ie = 0;

      // R8 priority: mb5 and mb12 tie (mb5 wins), mb9 extended, mb2 higher base
      load(4'd2,  29'h100 << 18, 1'b0, 1'b0, 4'd1);
      load(4'd5,  29'h050 << 18, 1'b0, 1'b0, 4'd2);
      load(4'd9,  (29'h050 << 18) | 29'd1, 1'b1, 1'b0, 4'd3);
      load(4'd12, 29'h050 << 18, 1'b0, 1'b0, 4'd4);
      pend(15'b000_1001_0001_0010);
      serve(2'b01, 0, 0, id, ide, rtr, dlc, dat);
      check("R8 first mb5", 64'(dlc), 2);
      serve(2'b01, 0, 0, id, ide, rtr, dlc, dat);
      check("R8 tie mb12", 64'(dlc), 4);
      serve(2'b01, 0, 0, id, ide, rtr, dlc, dat);
      check("R8 ext mb9", 64'(dlc), 3);
      serve(2'b01, 0, 0, id, ide, rtr, dlc, dat);
      check("R8 last mb2", 64'(dlc), 1);

      // R7 retry on lost arbitration and error
      @(negedge clk); ack_clr = 15'h7FFF;
      @(negedge clk); ack_clr = 0;
      load(4'd4, 29'h0000_0400, 1'b1, 1'b0, 4'd5);
      pend(15'(1) << 3);
      serve(2'b10, 0, 0, id, ide, rtr, dlc, dat);
      check("R7 lost keeps wait", 64'(tx_wait[4]), 1);
      check("R7 lost no ack", 64'(tx_ack[4]), 0);
      serve(2'b11, 0, 0, id, ide, rtr, dlc, dat);
      check("R7 retry offered", 64'(dlc), 5);
      check("R7 err keeps wait", 64'(tx_wait[4]), 1);

      // R9 re-selection: mb1 made pending during the attempt wins next
      load(4'd1, 29'h0, 1'b0, 1'b0, 4'd6);
      serve(2'b10, 0, 15'(1), id, ide, rtr, dlc, dat);
      serve(2'b01, 0, 0, id, ide, rtr, dlc, dat);
      check("R9 newcomer first", 64'(dlc), 6);
      // R10 set wins over same-edge clear for mb4
      serve(2'b01, 15'(1) << 3, 0, id, ide, rtr, dlc, dat);
      check("R9 then mb4", 64'(dlc), 5);
      check("R10 set beats clear", 64'(tx_ack[4]), 1);
      check("R6 all idle", 64'(tx_wait), 0);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule